// File: doc/BRIEF.md
# Dual Wiper Register and Tap Control

This block keeps the digital setting of two resistor-ladder channels. Each channel stores an 8-bit wiper code. The code is turned into a one-hot select over that channel's 256 tap switches. Bit 0 of a channel's select is the tap at the B end. Each step up in code moves the connection one tap toward A. Code 0xFF picks the last tap, which is one step short of the A end.

A serial front end, outside this block, presents each decoded write as one single-cycle strobe on the update port. The strobe carries:
- the target channel,
- a midscale flag,
- a shutdown command bit,
- two general-purpose logic-output bits,
- a data value.

Shutdown disconnects every tap, opens terminal A and shorts the wiper to terminal B. It can be requested in two ways, and either one is enough:
- an active-low pin, which acts at once without a clock;
- the latched command bit, which is active high.

The stored codes survive shutdown and are applied again when it ends.

A small state machine holds the command-driven mode. It has two states:
- `MODE_LIVE`: the taps follow the codes.
- `MODE_CMD_OFF`: shutdown was commanded.

An update with the command bit set moves it from `MODE_LIVE` to `MODE_CMD_OFF`. An update with the bit clear moves it back. With no update it stays where it is. The pin is combined with this state on the output side.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: After power-on reset, both wiper codes are 0x80, both logic outputs are 0, readback points at channel 1 and there is no commanded shutdown.
- R2: Outside shutdown, each channel's 256-bit select field has exactly one bit set, at the index equal to its code. Channel 1 occupies `tap_sel[255:0]` and channel 2 occupies `tap_sel[511:256]`.
- R3: An update with `upd_mid`=0 stores `upd_code` into the channel named by `upd_chan` (0 means channel 1, 1 means channel 2). The new code is visible from the clock edge that samples the update. The other channel is unchanged.
- R4: An update with `upd_mid`=1 sets the named channel to 0x80 and ignores `upd_code`.
- R5: While `shdn_n` is low, `tap_sel` is all zero and `a_open` and `wb_short` are 1. This takes effect without any clock edge.
- R6: `upd_sd` is latched by every update. When the latched bit is 1, the block is in shutdown from that edge on. A later update with `upd_sd`=0 ends it.
- R7: Shutdown leaves the stored codes intact, and updates during shutdown still store codes. On leaving shutdown, each channel's select again shows its stored code.
- R8: `lout` shows the `upd_lout` bits of the most recent update, whatever the codes are.
- R9: `rd_code` returns the code of the channel named by the most recent update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| upd_valid | input | 1 | Single-cycle update strobe |
| upd_chan | input | 1 | Target channel (0 = channel 1, 1 = channel 2) |
| upd_mid | input | 1 | Midscale request |
| upd_sd | input | 1 | Shutdown command bit, active high |
| upd_lout | input | 2 | Logic-output values to latch |
| upd_code | input | 8 | Wiper code |
| shdn_n | input | 1 | Shutdown pin, asynchronous, active low |
| tap_sel | output | 512 | One-hot tap selects, channel 1 in the low half |
| a_open | output | 1 | Open terminal A |
| wb_short | output | 1 | Short the wiper to terminal B |
| lout | output | 2 | Latched logic outputs |
| rd_code | output | 8 | Code of the most recently selected channel |

## Verification
A corrupted code register shows up in two places. It appears in `rd_code` at the first negative edge after the faulty write, provided that channel is selected. It also moves the set bit of `tap_sel` in the same cycle. A wrong mode state shows up at once as `a_open` and `wb_short` disagreeing with the last `upd_sd`. Because the bench compares every output against its model on every cycle, a fault is caught within one clock of when it first becomes visible. A fault in the pin path is checked inside a cycle, with no clock edge in between.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic {
        MODE_LIVE    = 1'b0,
        MODE_CMD_OFF = 1'b1
    } wtc_mode_e;
endpackage

// File: rtl/wtc_mode_fsm.sv
module wtc_mode_fsm
    import wtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_valid,
    input  logic upd_sd,
    input  logic shdn_n,
    output logic shut
);
    wtc_mode_e state_q, state_d;

    // Next-state logic: every update rewrites the commanded mode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_LIVE:    if (upd_valid && upd_sd)  state_d = MODE_CMD_OFF;
            MODE_CMD_OFF: if (upd_valid && !upd_sd) state_d = MODE_LIVE;
            default:      state_d = MODE_LIVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_LIVE;
        else        state_q <= state_d;
    end

    // Output: the pin overrides without a clock; the command state is registered.
    always_comb begin
        unique case (state_q)
            MODE_LIVE:    shut = !shdn_n;
            MODE_CMD_OFF: shut = 1'b1;
            default:      shut = 1'b1;
        endcase
    end

    // R6
    cmd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_sd) |=> shut);

    // R6
    cmd_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_sd && shdn_n) |=> (shut == !shdn_n));
endmodule

// File: rtl/wtc_chan_reg.sv
module wtc_chan_reg #(
    parameter int CODE_W = 8,
    parameter int SEL_W  = 1,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [SEL_W-1:0]  upd_chan,
    input  logic              upd_mid,
    input  logic [CODE_W-1:0] upd_code,
    output logic [CODE_W-1:0] code_q
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic hit;
    assign hit = upd_valid && (upd_chan == SEL_W'(CH_IDX));

    // Midscale request wins over the data value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= MID;
        else if (hit)     code_q <= upd_mid ? MID : upd_code;
    end

    // R4
    mid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && upd_mid) |=> (code_q == MID));

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(code_q));
endmodule

// File: rtl/wtc_tap_decode.sv
module wtc_tap_decode #(
    parameter int CODE_W = 8,
    parameter int TAPS   = 256
) (
    input  logic [CODE_W-1:0] code,
    input  logic              shut,
    output logic [TAPS-1:0]   taps
);
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign taps[k] = !shut && (code == CODE_W'(k));
    end
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int LO_W   = 2,
    localparam int TAPS  = 1 << CODE_W,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic [SEL_W-1:0]   upd_chan,
    input  logic               upd_mid,
    input  logic               upd_sd,
    input  logic [LO_W-1:0]    upd_lout,
    input  logic [CODE_W-1:0]  upd_code,
    input  logic               shdn_n,
    output logic [NCH*TAPS-1:0] tap_sel,
    output logic               a_open,
    output logic               wb_short,
    output logic [LO_W-1:0]    lout,
    output logic [CODE_W-1:0]  rd_code
);
    logic              shut;
    logic [CODE_W-1:0] codes [NCH];
    logic [SEL_W-1:0]  ptr_q;
    logic [LO_W-1:0]   lout_q;

    wtc_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_sd    (upd_sd),
        .shdn_n    (shdn_n),
        .shut      (shut)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        wtc_chan_reg #(.CODE_W(CODE_W), .SEL_W(SEL_W), .CH_IDX(c)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_valid (upd_valid),
            .upd_chan  (upd_chan),
            .upd_mid   (upd_mid),
            .upd_code  (upd_code),
            .code_q    (codes[c])
        );
        wtc_tap_decode #(.CODE_W(CODE_W), .TAPS(TAPS)) u_dec (
            .code (codes[c]),
            .shut (shut),
            .taps (tap_sel[c*TAPS +: TAPS])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            lout_q <= '0;
        end else if (upd_valid) begin
            ptr_q  <= upd_chan;
            lout_q <= upd_lout;
        end
    end

    assign a_open   = shut;
    assign wb_short = shut;
    assign lout     = lout_q;
    assign rd_code  = codes[ptr_q];

    // R5
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> (tap_sel == '0 && a_open && wb_short));

    // R2
    live_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_open |-> ($countones(tap_sel) == NCH));

    // R8
    lout_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (lout == $past(upd_lout)));
endmodule

// File: tb/wiper_tap_ctrl_test.sv
`timescale 1ns/1ps
module wiper_tap_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         upd_valid = 1'b0, upd_chan = 1'b0, upd_mid = 1'b0, upd_sd = 1'b0;
    logic [1:0]   upd_lout = 2'b00;
    logic [7:0]   upd_code = 8'h00;
    logic         shdn_n = 1'b1;
    logic [511:0] tap_sel;
    logic         a_open, wb_short;
    logic [1:0]   lout;
    logic [7:0]   rd_code;

    int n_chk = 0;
    int n_fail = 0;
    int m_code [2];
    int m_lout, m_ptr, m_sd;

    always #2.5 clk = ~clk;

    wiper_tap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_chan(upd_chan),
        .upd_mid(upd_mid), .upd_sd(upd_sd), .upd_lout(upd_lout), .upd_code(upd_code),
        .shdn_n(shdn_n), .tap_sel(tap_sel), .a_open(a_open), .wb_short(wb_short),
        .lout(lout), .rd_code(rd_code)
    );

    task automatic check(input string tag);
        logic [511:0] exp_taps;
        bit off;
        off = (m_sd != 0) || !shdn_n;
        exp_taps = '0;
        if (!off) begin
            exp_taps[m_code[0]] = 1'b1;
            exp_taps[256 + m_code[1]] = 1'b1;
        end
        n_chk++;
        if (tap_sel !== exp_taps) begin
            n_fail++;
            $display("FAIL %s tap_sel got ch1 idx/ch2 idx bits=%0d expected codes %0d/%0d off=%0d",
                     tag, $countones(tap_sel), m_code[0], m_code[1], off);
        end
        n_chk++;
        if (a_open !== off || wb_short !== off) begin
            n_fail++;
            $display("FAIL %s a_open=%0b wb_short=%0b expected %0b", tag, a_open, wb_short, off);
        end
        n_chk++;
        if (lout !== m_lout[1:0]) begin
            n_fail++;
            $display("FAIL %s lout=%0d expected %0d", tag, lout, m_lout);
        end
        n_chk++;
        if (rd_code !== m_code[m_ptr][7:0]) begin
            n_fail++;
            $display("FAIL %s rd_code=%0h expected %0h", tag, rd_code, m_code[m_ptr]);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        if (upd_valid) begin
            m_code[upd_chan] = upd_mid ? 128 : int'(upd_code);
            m_ptr  = upd_chan;
            m_lout = upd_lout;
            m_sd   = upd_sd;
        end
        @(negedge clk);
        upd_valid = 1'b0;
        check(tag);
    endtask

    task automatic upd(input bit ch, input bit mid, input bit sd, input logic [1:0] lo,
                       input logic [7:0] code, input string tag);
        upd_valid = 1'b1; upd_chan = ch; upd_mid = mid; upd_sd = sd;
        upd_lout = lo; upd_code = code;
        tick(tag);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_code[0] = 128; m_code[1] = 128; m_lout = 0; m_ptr = 0; m_sd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick("R1 reset state");
        tick("R1 reset hold");

        upd(0, 0, 0, 2'b00, 8'h00, "R2 R3 ch1 code 0 at B end");
        upd(1, 0, 0, 2'b00, 8'hFF, "R2 R3 ch2 code FF last tap");
        upd(0, 0, 0, 2'b01, 8'h37, "R3 ch1 write leaves ch2");
        upd(1, 1, 0, 2'b10, 8'h11, "R4 midscale ignores data");
        upd(0, 1, 0, 2'b11, 8'hEE, "R4 midscale ch1");
        upd(1, 0, 0, 2'b10, 8'h5A, "R8 R9 lout and readback ch2");
        tick("R9 readback holds");
        upd(0, 0, 0, 2'b01, 8'hA5, "R9 readback ch1");

        upd(0, 0, 1, 2'b11, 8'h05, "R6 command shutdown enter");
        tick("R6 shutdown persists");
        upd(1, 0, 1, 2'b00, 8'hC3, "R7 write during shutdown");
        upd(0, 0, 0, 2'b01, 8'h06, "R6 R7 command shutdown exit");

        shdn_n = 1'b0;
        #1 check("R5 pin acts without clock");
        @(negedge clk);
        check("R5 pin held");
        upd(0, 0, 0, 2'b10, 8'h44, "R7 write under pin shutdown");
        upd(1, 0, 1, 2'b10, 8'h99, "R5 R6 pin and command");
        shdn_n = 1'b1;
        #1 check("R6 command still holds after pin release");
        upd(1, 0, 0, 2'b00, 8'h99, "R7 restore stored codes");

        for (int i = 0; i < 40; i++) begin
            upd(i[0], (i % 7) == 3, 1'b0, i[2:1], 8'((i * 37) + 11), "R3 R4 pattern");
            if (i % 5 == 0) tick("R9 idle");
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule